// File: doc/BRIEF.md
# Analog Display Presence Probe Sequencer

This block runs a one-shot detection cycle that tells the host whether a monitor is attached to an analog video output. The host writes a control register with a start bit set. The block then waits for a programmable warm-up measured in millisecond ticks. After that it waits a short programmable settling time in clock cycles and captures the two comparator sense lines, one for the blue channel and one for the green channel. Each sense line passes through a two-flop synchronizer before it is captured.

When the cycle ends, the captured sense pair and a "present" flag appear in a status register. A sticky interrupt bit is raised, and the start bit drops by itself, so the host can poll the start bit as a busy flag. The host can ask for the cycle to run twice back to back, in which case only the second capture is reported. The host can also ask for the DAC to be switched off while the cycle runs. In that case the DAC enable bit is cleared at the start of the cycle and its earlier value is put back when the cycle ends.

Top module: `analog_presence_probe`

## Requirements
- R1: Writing the control register (address 0) with bit 0 set while the block is idle starts a cycle. Bit 0 of the control readback is 1 for the whole cycle and returns to 0 when the cycle ends.
- R2: The warm-up length is set by control bits [5:4]: 00 gives 5 ticks, 01 gives 10, 10 gives 20 and 11 gives 40 ticks of `ms_tick`.
- R3: After the warm-up, the block waits a settling time before it samples, set by control bit 6: 64 clocks when the bit is 0 and 128 clocks when it is 1.
- R4: At the end of the cycle, status bits [1:0] hold the synchronized sense pair sampled at the end of the last settling time, with blue in bit 0 and green in bit 1. Status bit 2 is 1 when this pair is nonzero. Both fields hold their value between cycles.
- R5: When control bit 3 is set, the warm-up, settle and sample sequence runs twice, and only the second sample is reported. The cycle takes about twice as long.
- R6: When control bit 2 (blank) is set together with the start bit, the DAC enable (control bit 1, and the `dac_on` output) is 0 for the whole cycle. Its written value is restored when the cycle ends. Without blank, `dac_on` follows control bit 1 throughout.
- R7: Status bit 4 is a sticky interrupt status that is set when each pass ends. Writing 1 to it at status address 1 clears it, and writing 0 leaves it unchanged.
- R8: While a cycle runs, writes to the control register are ignored, including a new start bit. The configuration read back after the cycle is the one that started it.
- R9: Reset clears the control register, the status register, the interrupt and `dac_on`, and abandons any cycle in progress.
- R10: The `irq` output always equals status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| sense_blue | input | 1 | Blue-channel load comparator, asynchronous |
| sense_green | input | 1 | Green-channel load comparator, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 status |
| rd_data | output | 8 | Read data, combinational |
| dac_on | output | 1 | DAC enable to the analog output stage |
| irq | output | 1 | Interrupt request, equal to status bit 4 |

## Verification
The assertions assume that `ms_tick` pulses last a single clock and are spaced further apart than the longest settling time, so that no tick lands in the settling window. They also assume that each register write lasts one clock. The bench drives a tick every 200 clocks and issues writes as single-cycle strobes between clock edges. The sense lines are allowed to change at any time. The bench changes them during a warm-up on purpose, to show that only the value present at the end of the settling time is reported.

// File: rtl/aprb_pkg.sv
package aprb_pkg;

    localparam int DATA_W = 8;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // control register, bit 0 is the start / busy bit
    typedef struct packed {
        logic       rsvd;
        logic       settle_sel;
        logic [1:0] warm_sel;
        logic       repeat2;
        logic       blank;
        logic       dac_en;
        logic       trig;
    } ctrl_t;

    // status register, sense[0] blue, sense[1] green
    typedef struct packed {
        logic [2:0] rsvd_hi;
        logic       irq;
        logic       rsvd_lo;
        logic       present;
        logic [1:0] sense;
    } stat_t;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_WARM   = 2'd1,
        SQ_SETTLE = 2'd2
    } seq_state_e;

    function automatic int warm_ticks(input logic [1:0] sel, input int base);
        return base << sel;
    endfunction

    function automatic int settle_clks(input logic sel, input int base);
        return sel ? (base * 2) : base;
    endfunction

endpackage

// File: rtl/aprb_sync.sv
module aprb_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1;
        logic s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/aprb_timer.sv
module aprb_timer #(
    parameter int TICK_W = 6,
    parameter int CLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              warm_run,
    input  logic              settle_run,
    input  logic              ms_tick,
    input  logic [TICK_W-1:0] warm_target,
    input  logic [CLK_W-1:0]  settle_target,
    output logic              warm_done,
    output logic              settle_done
);
    logic [TICK_W-1:0] tick_cnt;
    logic [CLK_W-1:0]  clk_cnt;

    assign warm_done   = (tick_cnt == warm_target);
    assign settle_done = (clk_cnt == CLK_W'(settle_target - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tick_cnt <= '0;
        end else if (warm_run && ms_tick && !warm_done) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            clk_cnt <= '0;
        end else if (settle_run && !settle_done) begin
            clk_cnt <= clk_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/aprb_seq.sv
module aprb_seq
    import aprb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic repeat2,
    input  logic warm_done,
    input  logic settle_done,
    output logic busy,
    output logic timer_clear,
    output logic warm_run,
    output logic settle_run,
    output logic pass_end,
    output logic cycle_end
);
    seq_state_e state_q, state_n;
    logic       second_q;

    assign busy       = (state_q != SQ_IDLE);
    assign warm_run   = (state_q == SQ_WARM);
    assign settle_run = (state_q == SQ_SETTLE);
    assign pass_end   = settle_run && settle_done;
    assign cycle_end  = pass_end && (!repeat2 || second_q);

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SQ_IDLE:   if (start) state_n = SQ_WARM;
            SQ_WARM:   if (warm_done) state_n = SQ_SETTLE;
            SQ_SETTLE: if (pass_end) state_n = cycle_end ? SQ_IDLE : SQ_WARM;
            default:   state_n = SQ_IDLE;
        endcase
    end

    assign timer_clear = (state_n != state_q) || (state_q == SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            second_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (start || cycle_end) begin
                second_q <= 1'b0;
            end else if (pass_end) begin
                second_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/aprb_regs.sv
module aprb_regs
    import aprb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              busy,
    input  logic              pass_end,
    input  logic              cycle_end,
    input  logic [1:0]        sense_q,
    output logic              start,
    output ctrl_t             ctrl_o,
    output stat_t             stat_o
);
    ctrl_t ctrl_q, ctrl_n;
    stat_t stat_q, stat_n;
    logic  saved_dac_q, saved_dac_n;
    logic  ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL) && !busy;
    assign start   = ctrl_wr && wr_data[0];

    always_comb begin
        ctrl_n      = ctrl_q;
        stat_n      = stat_q;
        saved_dac_n = saved_dac_q;
        if (ctrl_wr) begin
            ctrl_n      = ctrl_t'(wr_data);
            ctrl_n.trig = 1'b0;
            ctrl_n.rsvd = 1'b0;
            if (start) begin
                saved_dac_n = ctrl_n.dac_en;
                if (ctrl_n.blank) begin
                    ctrl_n.dac_en = 1'b0;
                end
            end
        end
        if (cycle_end && ctrl_q.blank) begin
            ctrl_n.dac_en = saved_dac_q;
        end
        if (wr_en && (wr_addr == ADDR_STAT) && wr_data[4]) begin
            stat_n.irq = 1'b0;
        end
        if (pass_end) begin
            stat_n.irq = 1'b1;
        end
        if (cycle_end) begin
            stat_n.sense   = sense_q;
            stat_n.present = |sense_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            stat_q      <= '0;
            saved_dac_q <= 1'b0;
        end else begin
            ctrl_q      <= ctrl_n;
            stat_q      <= stat_n;
            saved_dac_q <= saved_dac_n;
        end
    end

    assign ctrl_o  = ctrl_q;
    assign stat_o  = stat_q;
    assign rd_data = (rd_addr == ADDR_CTRL) ? (ctrl_q | {{(DATA_W-1){1'b0}}, busy})
                                            : stat_q;
endmodule

// File: rtl/analog_presence_probe.sv
module analog_presence_probe
    import aprb_pkg::*;
#(
    parameter int WARM_BASE_MS   = 5,
    parameter int SETTLE_BASE_CK = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_tick,
    input  logic              sense_blue,
    input  logic              sense_green,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              dac_on,
    output logic              irq
);
    localparam int TICK_W = $clog2(WARM_BASE_MS * 8 + 1);
    localparam int CLK_W  = $clog2(SETTLE_BASE_CK * 2 + 1);

    logic [1:0]        sense_q;
    logic              busy, start, pass_end, cycle_end;
    logic              timer_clear, warm_run, settle_run, warm_done, settle_done;
    logic [TICK_W-1:0] warm_target;
    logic [CLK_W-1:0]  settle_target;
    ctrl_t             ctrl_w;
    stat_t             stat_w;

    aprb_sync #(.W(2)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({sense_green, sense_blue}),
        .q   (sense_q)
    );

    assign warm_target   = TICK_W'(warm_ticks(ctrl_w.warm_sel, WARM_BASE_MS));
    assign settle_target = CLK_W'(settle_clks(ctrl_w.settle_sel, SETTLE_BASE_CK));

    aprb_timer #(.TICK_W(TICK_W), .CLK_W(CLK_W)) timer_i (
        .clk           (clk),
        .rst           (rst),
        .clear         (timer_clear),
        .warm_run      (warm_run),
        .settle_run    (settle_run),
        .ms_tick       (ms_tick),
        .warm_target   (warm_target),
        .settle_target (settle_target),
        .warm_done     (warm_done),
        .settle_done   (settle_done)
    );

    aprb_seq seq_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .repeat2     (ctrl_w.repeat2),
        .warm_done   (warm_done),
        .settle_done (settle_done),
        .busy        (busy),
        .timer_clear (timer_clear),
        .warm_run    (warm_run),
        .settle_run  (settle_run),
        .pass_end    (pass_end),
        .cycle_end   (cycle_end)
    );

    aprb_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .pass_end  (pass_end),
        .cycle_end (cycle_end),
        .sense_q   (sense_q),
        .start     (start),
        .ctrl_o    (ctrl_w),
        .stat_o    (stat_w)
    );

    assign dac_on = ctrl_w.dac_en;
    assign irq    = stat_w.irq;
endmodule

// File: rtl/aprb_checker.sv
module aprb_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       pass_end,
    input logic       cycle_end,
    input logic       dac_on,
    input logic       irq,
    input logic       blank,
    input logic       wr_en,
    input logic       wr_addr,
    input logic [7:0] wr_data,
    input logic [5:0] cfg_hi,
    input logic [1:0] result
);
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
        busy && !cycle_end |=> busy); // R1
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> !busy); // R1
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !cycle_end |=> $stable(result)); // R4
    AST_DAC_BLANKED: assert property (@(posedge clk) disable iff (rst)
        busy && blank |-> !dac_on); // R6
    AST_IRQ_ON_PASS: assert property (@(posedge clk) disable iff (rst)
        pass_end |=> irq); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        irq && !(wr_en && wr_addr && wr_data[4]) |=> irq); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy && !cycle_end |=> $stable(cfg_hi)); // R8
endmodule

bind analog_presence_probe aprb_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .pass_end  (pass_end),
    .cycle_end (cycle_end),
    .dac_on    (dac_on),
    .irq       (irq),
    .blank     (ctrl_w.blank),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cfg_hi    (ctrl_w[7:2]),
    .result    (stat_w.sense)
);

// File: tb/analog_presence_probe_tb_top.sv
`timescale 1ns/1ps
module analog_presence_probe_tb_top;
    localparam int P  = 200;   // clocks per ms tick
    localparam int NV = 6;
    // {ctrl[7:0], sense{green,blue}}
    localparam logic [9:0] VEC [NV] = '{
        {8'h01, 2'b00}, {8'h53, 2'b01}, {8'h29, 2'b10},
        {8'h77, 2'b11}, {8'h0F, 2'b11}, {8'h11, 2'b00}
    };

    logic clk = 0, rst = 1, ms_tick = 0, sense_blue = 0, sense_green = 0;
    logic wr_en = 0, wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic dac_on, irq;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    analog_presence_probe dut_i (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .sense_blue(sense_blue),
        .sense_green(sense_green), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dac_on(dac_on), .irq(irq)
    );

    initial begin
        forever begin
            repeat (P - 1) @(negedge clk);
            ms_tick = 1;
            @(negedge clk);
            ms_tick = 0;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired");
        errors++;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // counts read polls until bit 0 of control drops
    task automatic wait_idle(output int n, output bit blanked);
        logic [7:0] d;
        n = 0;
        blanked = 1;
        do begin
            rd(1'b0, d);
            n++;
            if (d[0] && (dac_on || d[1])) blanked = 0;
        end while (d[0] && n < 60000);
    endtask

    initial begin
        logic [7:0] d;
        int n, w, s, passes, lo, hi;
        bit blanked;
        repeat (4) @(negedge clk);
        rst = 0;

        // reset state
        rd(1'b0, d); chk(d == 8'h00, "R9 ctrl after reset", d, 0);
        rd(1'b1, d); chk(d == 8'h00, "R9 stat after reset", d, 0);
        chk(!dac_on && !irq, "R9 outputs after reset", {dac_on, irq}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] c;
            c = VEC[i][9:2];
            {sense_green, sense_blue} = VEC[i][1:0];
            w = 5 << c[5:4];
            s = c[6] ? 128 : 64;
            passes = c[3] ? 2 : 1;
            wr(1'b0, c);
            rd(1'b0, d);
            chk(d[0] == 1'b1, "R1 busy after start", d[0], 1);
            wait_idle(n, blanked);
            lo = passes * ((w - 1) * P + s) - 4;
            hi = passes * (w * P + s + 8) + 8;
            chk(n >= lo && n <= hi, "R2 R3 R5 cycle length", n, lo);
            if (c[2]) chk(blanked, "R6 DAC off during blanked cycle", blanked, 1);
            rd(1'b0, d);
            chk(d == {1'b0, c[6:1], 1'b0}, "R6 R1 ctrl after cycle", d, {1'b0, c[6:1], 1'b0});
            chk(dac_on == c[1], "R6 dac_on restored", dac_on, c[1]);
            rd(1'b1, d);
            chk(d == {3'b0, 1'b1, 1'b0, |VEC[i][1:0], VEC[i][1:0]}, "R4 R7 status",
                d, {3'b0, 1'b1, 1'b0, |VEC[i][1:0], VEC[i][1:0]});
            chk(irq == 1'b1, "R10 irq pin", irq, 1);
            wr(1'b1, 8'h00);
            rd(1'b1, d);
            chk(d[4] == 1'b1, "R7 write 0 keeps irq", d[4], 1);
            wr(1'b1, 8'h10);
            rd(1'b1, d);
            chk(d[4] == 1'b0 && !irq, "R7 R10 W1C clears irq", d[4], 0);
        end

        // R4: sense changes during warm-up, end value reported
        {sense_green, sense_blue} = 2'b00;
        wr(1'b0, 8'h01);
        repeat (2 * P) @(negedge clk);
        {sense_green, sense_blue} = 2'b11;
        wait_idle(n, blanked);
        rd(1'b1, d);
        chk(d[2:0] == 3'b111, "R4 late sense change sampled", d[2:0], 7);
        wr(1'b1, 8'h10);

        // R8: writes while busy are ignored
        wr(1'b0, 8'h01);
        repeat (20) @(negedge clk);
        wr(1'b0, 8'h7F);
        wait_idle(n, blanked);
        rd(1'b0, d);
        chk(d == 8'h00, "R8 busy write ignored", d, 0);
        repeat (5) @(negedge clk);
        rd(1'b0, d);
        chk(d[0] == 1'b0, "R8 no restart from busy trigger", d[0], 0);
        wr(1'b1, 8'h10);

        // R9: reset in mid-cycle
        wr(1'b0, 8'h07);
        repeat (300) @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        rd(1'b0, d); chk(d == 8'h00, "R9 ctrl after mid-cycle reset", d, 0);
        rd(1'b1, d); chk(d == 8'h00, "R9 stat after mid-cycle reset", d, 0);
        chk(!dac_on && !irq, "R9 outputs after mid-cycle reset", {dac_on, irq}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule